// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-driven SPI host that runs exactly one serial flash transaction each time software starts it. Software loads a command byte, a packed pair of byte counts (bytes to send after the command, bytes to collect afterwards) and the outgoing bytes into a small shared byte buffer. It then sets a start bit. The engine lowers chip select and shifts out the command byte, then the outgoing bytes. It shifts in the requested number of reply bytes, files them in the same buffer and releases chip select. The start bit stays set for the whole transfer, so it also serves as the busy flag.

The buffer is reached through a single data port. A pointer steps forward on every access and wraps at the buffer depth. Software can clear the pointer and read its value back. Reply bytes land in the slots that follow the outgoing bytes, so after clearing the pointer software reads past the outgoing slots before it reaches the first reply byte. The serial clock is the system clock divided by a parameter. The bus is SPI mode 0, MSB first.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low, and every register reads 0, including the busy bit and the pointer.
- R2: The byte at offset 0x0 is the first byte shifted out on MOSI in every transaction, most significant bit first.
- R3: Offset 0x1 holds the reply count in bits [7:4] and the outgoing count in bits [3:0]. A transaction gives exactly 8*(1+out+reply) SCK rising edges, and a zero count adds no bytes.
- R4: Writing 1 to bit 0 of offset 0x2 while idle starts a transaction. That bit reads 1 while it runs and returns to 0 by itself on the edge where chip select rises after the last reply bit. Chip select stays low for the whole transaction.
- R5: Writing 1 to bit 4 of offset 0x2 while idle clears the buffer pointer. The pointer reads back in bits [2:0] of offset 0xD, with the upper bits 0.
- R6: Each write or read at the data port (offset 0xC) while idle accesses the slot the pointer names and then advances the pointer by one, modulo 8.
- R7: Outgoing byte i is taken from buffer slot i mod 8. Reply byte k is stored in slot (out+k) mod 8.
- R8: SCK idles low. Each SCK half-period lasts CLK_DIV system clocks, with the first rising edge CLK_DIV clocks after the start. MOSI changes only while SCK is low, and MISO is sampled on the rising edge.
- R9: While a transaction runs, writes to offsets 0x0, 0x1, 0x2 and 0xC, and reads of 0xC, change no register, buffer slot or pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the pointer at the data port) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from offset |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A corrupted bit or byte counter shows at the pins within one SCK period. The frame ends early or late, and chip select and the busy bit then disagree with the cycle-exact pin model. A wrong buffer slot index does not show during the transfer. It appears only when software rewinds the pointer and reads back, as a reply byte in the wrong slot or an outgoing byte that was overwritten. A pointer that moves while busy shows on the very next read of offset 0xD.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_OPCODE  = 4'h0;
    localparam logic [ADDR_W-1:0] A_LENGTHS = 4'h1;
    localparam logic [ADDR_W-1:0] A_CONTROL = 4'h2;
    localparam logic [ADDR_W-1:0] A_DATA    = 4'hC;
    localparam logic [ADDR_W-1:0] A_POINTER = 4'hD;
    localparam int CTL_GO      = 0;
    localparam int CTL_PTR_CLR = 4;
    localparam int LEN_W       = 4;
endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == CW'(DIV - 1));

    always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 8,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [PW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [PW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] mem_q [DEPTH];

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
    parameter int CLK_DIV    = 2,
    parameter int FIFO_DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_sck,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    import spi_cmd_pkg::*;

    localparam int PTR_W = $clog2(FIFO_DEPTH);
    localparam int IDX_W = $clog2(2 * (1 << LEN_W));

    typedef struct packed {
        logic             busy;
        logic [7:0]       opcode;
        logic [LEN_W-1:0] rx_n;
        logic [LEN_W-1:0] tx_n;
        logic [PTR_W-1:0] ptr;
        logic             sck;
        logic             cs_n;
        logic [7:0]       tx_sh;
        logic [7:0]       rx_sh;
        logic [2:0]       bit_n;
        logic [IDX_W-1:0] byte_n;
    } eng_t;

    eng_t st_d, st_q;

    logic             tick;
    logic             buf_we;
    logic [PTR_W-1:0] buf_wa;
    logic [7:0]       buf_wd;
    logic [7:0]       buf_host_rd;
    logic [7:0]       buf_next_tx;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] next_idx;

    // signals for the bound checker
    logic       busy_w;
    logic [7:0] counts_w;
    assign busy_w   = st_q.busy;
    assign counts_w = {st_q.rx_n, st_q.tx_n};

    spi_sck_div #(.DIV(CLK_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_q.busy),
        .tick (tick)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .PW(PTR_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (buf_we),
        .waddr  (buf_wa),
        .wdata  (buf_wd),
        .raddr_a(st_q.ptr),
        .rdata_a(buf_host_rd),
        .raddr_b(PTR_W'(st_q.byte_n)),
        .rdata_b(buf_next_tx)
    );

    assign last_idx = IDX_W'(st_q.tx_n) + IDX_W'(st_q.rx_n);
    assign next_idx = st_q.byte_n + IDX_W'(1);

    always_comb begin
        st_d   = st_q;
        buf_we = 1'b0;
        buf_wa = st_q.ptr;
        buf_wd = reg_wdata;
        if (!st_q.busy) begin
            if (reg_wr) begin
                case (reg_addr)
                    A_OPCODE:  st_d.opcode = reg_wdata;
                    A_LENGTHS: {st_d.rx_n, st_d.tx_n} = reg_wdata;
                    A_DATA: begin
                        buf_we   = 1'b1;
                        st_d.ptr = st_q.ptr + PTR_W'(1);
                    end
                    A_CONTROL: begin
                        if (reg_wdata[CTL_PTR_CLR]) st_d.ptr = '0;
                        if (reg_wdata[CTL_GO]) begin
                            st_d.busy   = 1'b1;
                            st_d.cs_n   = 1'b0;
                            st_d.sck    = 1'b0;
                            st_d.tx_sh  = st_q.opcode;
                            st_d.bit_n  = '0;
                            st_d.byte_n = '0;
                        end
                    end
                    default: ;
                endcase
            end else if (reg_rd && reg_addr == A_DATA) begin
                st_d.ptr = st_q.ptr + PTR_W'(1);
            end
        end else if (tick) begin
            if (!st_q.sck) begin
                st_d.sck   = 1'b1;
                st_d.rx_sh = {st_q.rx_sh[6:0], spi_miso};
            end else begin
                st_d.sck   = 1'b0;
                st_d.bit_n = st_q.bit_n + 3'd1;
                if (st_q.bit_n == 3'd7) begin
                    if (st_q.byte_n > IDX_W'(st_q.tx_n)) begin
                        buf_we = 1'b1;
                        buf_wa = PTR_W'(st_q.byte_n - IDX_W'(1));
                        buf_wd = st_q.rx_sh;
                    end
                    if (st_q.byte_n == last_idx) begin
                        st_d.busy  = 1'b0;
                        st_d.cs_n  = 1'b1;
                        st_d.tx_sh = '0;
                    end else begin
                        st_d.byte_n = next_idx;
                        st_d.tx_sh  = (next_idx <= IDX_W'(st_q.tx_n)) ? buf_next_tx : 8'h00;
                    end
                end else begin
                    st_d.tx_sh = {st_q.tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            A_OPCODE:  reg_rdata = st_q.opcode;
            A_LENGTHS: reg_rdata = {st_q.rx_n, st_q.tx_n};
            A_CONTROL: reg_rdata = {7'b0, st_q.busy};
            A_DATA:    reg_rdata = buf_host_rd;
            A_POINTER: reg_rdata = {{(8 - PTR_W){1'b0}}, st_q.ptr};
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign spi_sck  = st_q.sck;
    assign spi_cs_n = st_q.cs_n;
    assign spi_mosi = st_q.tx_sh[7];
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
    parameter int CLK_DIV = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sck,
    input logic       cs_n,
    input logic       mosi,
    input logic       busy,
    input logic [7:0] counts
);
    logic        sck_seen, cs_seen;
    logic [15:0] gap;
    logic [9:0]  rises;
    logic [9:0]  frame_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_seen   <= 1'b0;
            cs_seen    <= 1'b1;
            gap        <= '0;
            rises      <= '0;
            frame_bits <= '0;
        end else begin
            sck_seen <= sck;
            cs_seen  <= cs_n;
            if (sck != sck_seen || cs_n != cs_seen) gap <= '0;
            else if (gap != 16'hFFFF)               gap <= gap + 16'd1;
            if (cs_n)                  rises <= '0;
            else if (sck && !sck_seen) rises <= rises + 10'd1;
            if (!cs_n && cs_seen)
                frame_bits <= 10'd8 * (10'd1 + 10'(counts[3:0]) + 10'(counts[7:4]));
        end
    end

    AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R8

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sck) |-> $stable(mosi)); // R8

    AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sck != sck_seen) |-> gap == 16'(CLK_DIV - 1)); // R8

    AST_FRAME_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cs_seen) |-> rises == frame_bits); // R3

    AST_COUNTS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(counts)); // R9

    AST_BUSY_CS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        busy != cs_n); // R4
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sck   (spi_sck),
    .cs_n  (spi_cs_n),
    .mosi  (spi_mosi),
    .busy  (busy_w),
    .counts(counts_w)
);

// File: tb/tb_spi_cmd_engine.sv
`timescale 1ns/100ps
module tb_spi_cmd_engine;
    localparam int D = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    always #2.5 clk = ~clk;

    spi_cmd_engine #(.CLK_DIV(D), .FIFO_DEPTH(8)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    bit         m_busy = 0;
    int         j = 0;
    int         nbits = 0;
    int         rise_k = 0;
    int         txn = 0;
    bit         just_started = 0;
    logic [7:0] m_op = 0, m_cnt = 0;
    logic [7:0] m_fifo [8];
    int         m_ptr = 0;
    logic [7:0] stream [32];
    logic [7:0] resp [16];
    logic       sck_prev = 0;

    function automatic logic miso_bit(input int k);
        int first_rx;
        first_rx = 8 * (1 + int'(m_cnt[3:0]));
        if (k >= first_rx) return resp[(k - first_rx) / 8][7 - (k % 8)];
        return logic'(k % 3 == 0);
    endfunction

    function automatic logic [7:0] model_read(input logic [3:0] a);
        case (a)
            4'h0: return m_op;
            4'h1: return m_cnt;
            4'h2: return {7'b0, m_busy};
            4'hC: return m_fifo[m_ptr];
            4'hD: return 8'(m_ptr);
            default: return 8'h00;
        endcase
    endfunction

    initial for (int i = 0; i < 8; i++) m_fifo[i] = 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_op = 0; m_cnt = 0; m_ptr = 0;
            for (int i = 0; i < 8; i++) m_fifo[i] = 8'h00;
        end else if (m_busy) begin
            j++;
            if (j >= nbits * 2 * D) begin
                m_busy = 0;
                for (int r = 0; r < int'(m_cnt[7:4]); r++)
                    m_fifo[(int'(m_cnt[3:0]) + r) % 8] = resp[r];
            end
        end else if (reg_wr) begin
            case (reg_addr)
                4'h0: m_op = reg_wdata;
                4'h1: m_cnt = reg_wdata;
                4'hC: begin m_fifo[m_ptr] = reg_wdata; m_ptr = (m_ptr + 1) % 8; end
                4'h2: begin
                    if (reg_wdata[4]) m_ptr = 0;
                    if (reg_wdata[0]) begin
                        txn++;
                        stream[0] = m_op;
                        for (int i = 1; i < 32; i++)
                            stream[i] = (i <= int'(m_cnt[3:0])) ? m_fifo[(i - 1) % 8] : 8'h00;
                        for (int r = 0; r < 16; r++)
                            resp[r] = 8'((txn * 53 + r * 29 + 8'h3C) ^ (r << 4));
                        nbits = 8 * (1 + int'(m_cnt[3:0]) + int'(m_cnt[7:4]));
                        j = 0; rise_k = 0; m_busy = 1; just_started = 1;
                    end
                end
                default: ;
            endcase
        end else if (reg_rd && reg_addr == 4'hC) begin
            m_ptr = (m_ptr + 1) % 8;
        end
        #1;
        if (rst_n) begin
            chk(spi_cs_n == !m_busy, "R4", "cs_n", spi_cs_n, !m_busy);
            chk(spi_sck == (m_busy && ((j / D) % 2 == 1)), "R8", "sck",
                spi_sck, (m_busy && ((j / D) % 2 == 1)));
            if (just_started) begin
                spi_miso = miso_bit(0);
                just_started = 0;
            end else if (m_busy && spi_sck && !sck_prev) begin
                chk(spi_mosi == stream[rise_k / 8][7 - (rise_k % 8)],
                    (rise_k < 8) ? "R2" : "R7", "mosi bit", spi_mosi,
                    stream[rise_k / 8][7 - (rise_k % 8)]);
                rise_k++;
                spi_miso = miso_bit(rise_k);
            end
        end
        sck_prev = spi_sck;
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string req, input bit do_chk,
                      output logic [7:0] v);
        logic [7:0] e;
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1;
        e = model_read(a);
        v = reg_rdata;
        if (do_chk) chk(v == e, req, "reg read", v, e);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] v;
        for (int n = 0; n < 2000; n++) begin
            rd(4'h2, req, 1'b1, v);
            if (!v[0]) break;
        end
    endtask

    task automatic run_txn(input logic [7:0] op, input logic [7:0] cnt,
                           input int ntx, input int base);
        wr(4'h0, op);
        wr(4'h1, cnt);
        wr(4'h2, 8'h10);
        for (int i = 0; i < ntx; i++) wr(4'hC, 8'(base + 17 * i));
        wr(4'h2, 8'h11);
    endtask

    task automatic readback(input int n, input string req);
        logic [7:0] v;
        wr(4'h2, 8'h10);
        for (int i = 0; i < n; i++) rd(4'hC, req, 1'b1, v);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1", "pins in reset",
            {spi_cs_n, spi_sck}, 2'b10);
        rst_n = 1'b1;
        rd(4'h0, "R1", 1'b1, v);
        rd(4'h1, "R1", 1'b1, v);
        rd(4'h2, "R1", 1'b1, v);
        rd(4'hD, "R1", 1'b1, v);

        // command byte only, both counts zero (R2 R3)
        run_txn(8'h06, 8'h00, 0, 0);
        wait_idle("R4");

        // one out, one reply (R3 R7)
        run_txn(8'h05, 8'h11, 1, 8'h40);
        wait_idle("R4");
        readback(2, "R7");

        // seven out, busy bit seen mid-frame (R4)
        run_txn(8'h02, 8'h07, 7, 8'h11);
        rd(4'h2, "R4", 1'b1, v);
        chk(v[0] == 1'b1, "R4", "busy while running", v[0], 1);
        wait_idle("R4");
        readback(7, "R7");

        // three out, two reply
        run_txn(8'h90, 8'h23, 3, 8'h00);
        wait_idle("R4");
        readback(5, "R7");

        // reply bytes wrap around the buffer (R6 R7)
        run_txn(8'h9F, 8'h65, 5, 8'h71);
        wait_idle("R4");
        readback(8, "R6");
        rd(4'hD, "R6", 1'b1, v);
        chk(v == 8'h00, "R6", "pointer wrapped", v, 0);

        // accesses during a long transfer are ignored (R9)
        run_txn(8'h0B, 8'hF2, 2, 8'h2A);
        wr(4'h0, 8'hEE);
        wr(4'h1, 8'h33);
        wr(4'hC, 8'h99);
        wr(4'h2, 8'h10);
        rd(4'hC, "R9", 1'b0, v);
        rd(4'hD, "R9", 1'b1, v);
        wait_idle("R9");
        rd(4'h0, "R9", 1'b1, v);
        rd(4'h1, "R9", 1'b1, v);
        rd(4'hD, "R9", 1'b1, v);
        readback(8, "R9");

        // pointer clear and readback (R5)
        wr(4'hC, 8'hA1);
        wr(4'hC, 8'hA2);
        wr(4'hC, 8'hA3);
        rd(4'hD, "R5", 1'b1, v);
        chk(v == 8'h03, "R5", "pointer after three writes", v, 3);
        wr(4'h2, 8'h10);
        rd(4'hD, "R5", 1'b1, v);
        chk(v == 8'h00, "R5", "pointer cleared", v, 0);
        rd(4'h2, "R5", 1'b1, v);
        chk(v == 8'h00, "R5", "clear bit does not start", v, 0);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule